// File: doc/BRIEF.md
# Byte-Level I2C Master Controller

This block is an I2C bus master that a host processor steers one byte at a time through three small registers: control, data and status. The host asks for a start condition. It then loads the data register with the slave address byte, and later with each payload byte. It releases the controller after every step by writing the control register. After each bus event the controller stops with SCL held low, writes a numbered code into the status register and raises a serial-interrupt flag. That flag also drives the interrupt request line, so the host learns of each event without polling.

SCL and SDA are modelled as open-drain wires. The block only pulls a line low, through an output-enable, and reads the resolved level back, which an external pull-up sets. Because both lines are read back, the block can detect when another master takes the bus. The bit rate comes from a quarter-bit tick whose divider is picked by a 3-bit rate field in the control register.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, irq is 0, both output-enables are 0, the control register reads 0x00 and the status register reads 0xF8.
- R2: Register offsets are control 0, data 1 and status 2. Control bits are [2:0] rate, [3] serial-interrupt flag (SI, read-only), [4] stop request and [5] start request. The status register ignores writes, writing 1 to the SI bit has no effect, and offset 3 reads 0x00.
- R3: A control write with bit 5 set, made while no transfer is in progress, waits until both lines read high. It then pulls SDA low while SCL is high, pulls SCL low, sets SI and loads status 0x08.
- R4: irq follows SI. SI stays 1 until the next control write, and every control write clears it. While SI is 1 with any status other than 0x38, SCL is held low. The status register changes only in the cycle that SI rises.
- R5: A control write with bit 4 clear, made while the controller is held, sends the data register MSB first on eight SCL pulses. SDA changes only while SCL is low. A ninth pulse follows with SDA released, so the slave can acknowledge. Bit 5 is ignored in this case.
- R6: After the first byte that follows a start, status is 0x18 if SDA was low on the ninth pulse (ACK) and 0x20 if it was high (NACK).
- R7: After any later byte, status is 0x28 on ACK and 0x30 on NACK.
- R8: When the block leaves SDA released for a 1 bit but reads it low while SCL is high, it releases both lines at once, sets SI and loads status 0x38.
- R9: A control write with bit 4 set, made while the controller is held, produces a stop condition: SDA rises while SCL is high. Both lines end released, SI stays 0 and status keeps its value.
- R10: During a byte the SCL period is 4 × QDIV_BASE × 2^rate system-clock cycles, where rate is control bits [2:0].
- R11: After a control write clears SI, SI is not raised again until the next bus event completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request, equal to SI |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The hardest case to reach from the ports is a lost arbitration: SDA has to be forced low at exactly the moment the controller has released it for a 1 bit with SCL high. The bench models a second party on the wired-AND SDA line. It pulls SDA low while the controller is held and then releases an address byte whose first bit is 1, so the loss occurs at the first sample. The same pull, applied before a start request, also keeps the bus busy. This shows that the start waits and is issued only once the line is freed.

// File: rtl/i2c_byte_pkg.sv
package i2c_byte_pkg;

    localparam int RATE_W = 3;

    localparam logic [1:0] RA_CTL = 2'd0;
    localparam logic [1:0] RA_DAT = 2'd1;
    localparam logic [1:0] RA_STS = 2'd2;

    localparam int CB_SI  = 3;
    localparam int CB_STO = 4;
    localparam int CB_STA = 5;

    localparam logic [7:0] ST_START    = 8'h08;
    localparam logic [7:0] ST_ADR_ACK  = 8'h18;
    localparam logic [7:0] ST_ADR_NACK = 8'h20;
    localparam logic [7:0] ST_DAT_ACK  = 8'h28;
    localparam logic [7:0] ST_DAT_NACK = 8'h30;
    localparam logic [7:0] ST_LOST     = 8'h38;
    localparam logic [7:0] ST_NONE     = 8'hF8;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_START,
        EN_BIT,
        EN_HOLD,
        EN_STOP
    } eng_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] code;
    } bus_event_t;

    function automatic logic [7:0] ack_code(input logic first, input logic acked);
        if (first) return acked ? ST_ADR_ACK : ST_ADR_NACK;
        return acked ? ST_DAT_ACK : ST_DAT_NACK;
    endfunction

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick
    import i2c_byte_pkg::*;
#(
    parameter int QDIV_BASE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int MAX_DIV = QDIV_BASE << ((1 << RATE_W) - 1);
    localparam int CW      = $clog2(MAX_DIV) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = CW'(QDIV_BASE) << rate;
    assign tick  = (cnt >= limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (tick) cnt <= '0;
        else cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_byte_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       sta_pend,
    input  logic       ctl_wr,
    input  logic       wr_sto,
    input  logic [7:0] data_byte,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output bus_event_t ev,
    output logic       start_taken,
    output logic       stop_done,
    output eng_state_e state
);
    logic [1:0] ph;
    logic [3:0] idx;
    logic [7:0] shreg;
    logic       first;
    logic       ack_q;

    always_ff @(posedge clk) begin
        ev          <= '0;
        start_taken <= 1'b0;
        stop_done   <= 1'b0;
        if (rst) begin
            state  <= EN_IDLE;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            ph     <= '0;
            idx    <= '0;
            shreg  <= '0;
            first  <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            case (state)
                EN_IDLE: begin
                    scl_oe <= 1'b0;
                    sda_oe <= 1'b0;
                    if (tick && sta_pend && scl_in && sda_in) begin
                        sda_oe      <= 1'b1;
                        start_taken <= 1'b1;
                        state       <= EN_START;
                    end
                end
                EN_START: if (tick) begin
                    scl_oe <= 1'b1;
                    first  <= 1'b1;
                    ev     <= '{valid: 1'b1, code: ST_START};
                    state  <= EN_HOLD;
                end
                EN_HOLD: if (ctl_wr) begin
                    ph <= '0;
                    if (wr_sto) begin
                        state <= EN_STOP;
                    end else begin
                        shreg <= data_byte;
                        idx   <= '0;
                        state <= EN_BIT;
                    end
                end
                EN_BIT: if (tick) begin
                    ph <= ph + 2'd1;
                    case (ph)
                        2'd0: sda_oe <= (idx == 4'd8) ? 1'b0 : ~shreg[7];
                        2'd1: scl_oe <= 1'b0;
                        2'd2: begin
                            if (idx != 4'd8 && !sda_oe && !sda_in) begin
                                scl_oe <= 1'b0;
                                sda_oe <= 1'b0;
                                ev     <= '{valid: 1'b1, code: ST_LOST};
                                state  <= EN_IDLE;
                            end
                            if (idx == 4'd8) ack_q <= ~sda_in;
                        end
                        default: begin
                            scl_oe <= 1'b1;
                            if (idx == 4'd8) begin
                                ev    <= '{valid: 1'b1, code: ack_code(first, ack_q)};
                                first <= 1'b0;
                                state <= EN_HOLD;
                            end else begin
                                idx   <= idx + 4'd1;
                                shreg <= {shreg[6:0], 1'b0};
                            end
                        end
                    endcase
                end
                EN_STOP: if (tick) begin
                    ph <= ph + 2'd1;
                    case (ph)
                        2'd0: sda_oe <= 1'b1;
                        2'd1: scl_oe <= 1'b0;
                        default: begin
                            sda_oe    <= 1'b0;
                            stop_done <= 1'b1;
                            state     <= EN_IDLE;
                        end
                    endcase
                end
                default: state <= EN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_byte_pkg::*;
#(
    parameter int QDIV_BASE = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    logic              ctl_wr, dat_wr;
    logic              si_q, sta_pend, sto_q;
    logic [RATE_W-1:0] rate_q;
    logic [7:0]        data_q, status_q;
    logic              tick, start_taken, stop_done;
    bus_event_t        ev;
    eng_state_e        eng_state;

    assign ctl_wr = bus_we && (bus_addr == RA_CTL);
    assign dat_wr = bus_we && (bus_addr == RA_DAT);
    assign irq    = si_q;

    i2c_qtick #(.QDIV_BASE(QDIV_BASE)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .rate (rate_q),
        .tick (tick)
    );

    i2c_bit_engine u_eng (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .sta_pend    (sta_pend),
        .ctl_wr      (ctl_wr),
        .wr_sto      (bus_wdata[CB_STO]),
        .data_byte   (data_q),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .ev          (ev),
        .start_taken (start_taken),
        .stop_done   (stop_done),
        .state       (eng_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            si_q     <= 1'b0;
            sta_pend <= 1'b0;
            sto_q    <= 1'b0;
            rate_q   <= '0;
            data_q   <= '0;
            status_q <= ST_NONE;
        end else begin
            if (ctl_wr) begin
                si_q   <= 1'b0;
                rate_q <= bus_wdata[RATE_W-1:0];
                if (bus_wdata[CB_STA] && eng_state == EN_IDLE) sta_pend <= 1'b1;
                if (bus_wdata[CB_STO] && eng_state == EN_HOLD) sto_q <= 1'b1;
            end
            if (start_taken) sta_pend <= 1'b0;
            if (stop_done) sto_q <= 1'b0;
            if (ev.valid) begin
                si_q     <= 1'b1;
                status_q <= ev.code;
            end
            if (dat_wr) data_q <= bus_wdata;
        end
    end

    always_comb begin
        case (bus_addr)
            RA_CTL:  bus_rdata = {2'b00, sta_pend, sto_q, si_q, rate_q};
            RA_DAT:  bus_rdata = data_q;
            RA_STS:  bus_rdata = status_q;
            default: bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       ctl_wr,
    input logic [7:0] status,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       scl_in,
    input logic       sda_in
);
    // R4
    si_hold_chk: assert property (@(posedge clk) disable iff (rst)
        irq && !ctl_wr |=> irq);

    // R4
    scl_held_chk: assert property (@(posedge clk) disable iff (rst)
        irq && status != 8'h38 |-> scl_oe);

    // R4
    status_event_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(status) |-> $rose(irq));

    // R8
    lost_release_chk: assert property (@(posedge clk) disable iff (rst)
        irq && status == 8'h38 |-> !scl_oe && !sda_oe);

    // R3
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) && !scl_oe |-> $past(scl_in) && $past(sda_in));

    // R11
    no_resi_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && irq |=> !irq);
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .irq    (irq),
    .ctl_wr (ctl_wr),
    .status (status_q),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .scl_in (scl_in),
    .sda_in (sda_in)
);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
    localparam int QDIV = 2;

    typedef struct packed {
        logic [7:0] adr;
        logic       ack_a;
        logic [7:0] dat;
        logic       ack_d;
        logic [2:0] rate;
        logic [7:0] st_a;
        logic [7:0] st_d;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'hA4, 1'b1, 8'h5C, 1'b1, 3'd0, 8'h18, 8'h28},
        '{8'h3E, 1'b0, 8'hC1, 1'b1, 3'd1, 8'h20, 8'h28},
        '{8'h92, 1'b1, 8'hFF, 1'b0, 3'd2, 8'h18, 8'h30},
        '{8'h01, 1'b0, 8'h00, 1'b0, 3'd0, 8'h20, 8'h30}
    };

    logic       clk = 0;
    logic       rst = 1;
    logic [1:0] bus_addr = 0;
    logic       bus_we = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       slave_pull = 0, arb_pull = 0, ack_en = 0;
    logic       scl_line, sda_line;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slave_pull || arb_pull);

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    i2c_byte_master #(.QDIV_BASE(QDIV)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // slave model on the wired-AND lines
    int         bitcnt = 0;
    bit         skip = 0, stop_seen = 0;
    logic [7:0] rx = 0;

    always @(negedge sda_line) if (scl_line === 1'b1) begin
        bitcnt = 0; skip = 1; slave_pull = 0;
    end
    always @(posedge sda_line) if (scl_line === 1'b1) stop_seen = 1;
    always @(posedge scl_line) if (bitcnt < 8) rx = {rx[6:0], sda_line};
    always @(negedge scl_line) begin
        if (skip) skip = 0;
        else if (bitcnt == 7) begin slave_pull = ack_en; bitcnt = 8; end
        else if (bitcnt == 8) begin slave_pull = 0; bitcnt = 0; end
        else bitcnt++;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (irq !== 1'b1 && n < 30000) begin @(negedge clk); n++; end
        if (irq !== 1'b1) chk({tag, " irq timeout"}, {7'd0, irq}, 8'h01);
    endtask

    logic [7:0] v;
    int t0, t1;

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        // R1 reset state
        @(negedge clk);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 oe", {6'd0, scl_oe, sda_oe}, 8'h00);
        rd(2'd0, v); chk("R1 ctl", v, 8'h00);
        rd(2'd2, v); chk("R1 status", v, 8'hF8);
        // R2 map behaviour
        wr(2'd2, 8'h00); rd(2'd2, v); chk("R2 status write ignored", v, 8'hF8);
        wr(2'd0, 8'h08); rd(2'd0, v); chk("R2 SI write ignored", v, 8'h00);
        chk("R2 irq after SI write", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h6B); rd(2'd1, v); chk("R2 data readback", v, 8'h6B);
        rd(2'd3, v); chk("R2 offset3", v, 8'h00);

        foreach (VECS[i]) begin
            vec_t t = VECS[i];
            stop_seen = 0;
            wr(2'd0, {5'b00100, t.rate});
            wait_irq("R3");
            rd(2'd2, v); chk("R3 start status", v, 8'h08);
            chk("R4 scl held", {7'd0, scl_oe}, 8'h01);
            repeat (30) @(negedge clk);
            chk("R4 irq stays", {7'd0, irq}, 8'h01);
            ack_en = t.ack_a;
            wr(2'd1, t.adr);
            wr(2'd0, {5'b00000, t.rate});
            repeat (4) @(negedge clk);
            chk("R11 irq cleared", {7'd0, irq}, 8'h00);
            wait_irq("R6");
            chk("R5 address bits", rx, t.adr);
            rd(2'd2, v); chk("R6 address status", v, t.st_a);
            ack_en = t.ack_d;
            wr(2'd1, t.dat);
            wr(2'd0, {5'b00100, t.rate}); // start bit ignored while held
            @(posedge scl_line); t0 = cyc;
            @(posedge scl_line); t1 = cyc;
            chk("R10 scl period", 8'(t1 - t0), 8'(4 * QDIV * (1 << t.rate)));
            wait_irq("R7");
            chk("R5 data bits", rx, t.dat);
            rd(2'd2, v); chk("R7 data status", v, t.st_d);
            wr(2'd0, {5'b00010, t.rate});
            repeat (200) @(negedge clk);
            chk("R9 stop seen", {7'd0, stop_seen}, 8'h01);
            chk("R9 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
            chk("R9 irq low", {7'd0, irq}, 8'h00);
            rd(2'd2, v); chk("R9 status kept", v, t.st_d);
        end

        // R3 start waits for a busy bus
        arb_pull = 1;
        wr(2'd0, 8'h20);
        repeat (100) @(negedge clk);
        chk("R3 no start on busy bus", {6'd0, irq, sda_oe}, 8'h00);
        arb_pull = 0;
        wait_irq("R3");
        rd(2'd2, v); chk("R3 start after release", v, 8'h08);

        // R8 arbitration loss on first bit of 0x80
        arb_pull = 1;
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h00);
        wait_irq("R8");
        rd(2'd2, v); chk("R8 lost status", v, 8'h38);
        chk("R8 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
        arb_pull = 0;
        wr(2'd0, 8'h00);
        repeat (50) @(negedge clk);
        chk("R4 irq cleared by write", {7'd0, irq}, 8'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule